// File: doc/BRIEF.md
# Self-Calibrating Tracking ADC Sequencer

This block sequences a single-bit ADC modulator whose input can be steered to the external pin, to ground or to the supply rail. It runs a repeating cycle of four windows of equal length N clocks: a ground window, a pin window, a supply window and a second pin window. It counts modulator ones in every window. The ground count sets the zero point, and each pin count is reported with that ground count taken away.

After every supply window the block compares the span between the supply and ground counts with the full-scale code of the selected resolution. It then moves N by one clock toward the length at which the span equals full scale. The reported samples therefore come out zeroed and scaled with nothing more than counters and preloads. Software picks 8-, 10- or 12-bit resolution. It can also ask for results to be clipped into the code range; otherwise readings slightly outside the rails stay visible as negative or over-range values.

Top module: `adc_cal_sequencer`

## Requirements
- R1: Input select encoding: 0 = pin, 1 = ground, 2 = supply. The select runs ground, pin, supply, pin and then repeats, with every window exactly N clocks long.
- R2: While reset is held, N is 300 (8-bit mode), the select shows ground, and sample, sampleValid and tracking are all zero.
- R3: At the end of each ground window the ones counted over its N clocks are stored. Each pin sample equals the pin window's ones minus the most recently stored ground count, as a signed 32-bit value that may be negative or above full scale.
- R4: sampleValid is high for exactly one clock, the clock after the last clock of each pin window. sample changes only at that point and holds otherwise.
- R5: At the end of the supply window the span is the supply count minus the ground count. N decreases by one if the span is above full scale, increases by one if it is below, and stays the same if equal. The new N applies from the next ground window.
- R6: N never goes below the full scale of the current mode and never goes above four times that mode's starting N.
- R7: tracking is updated one clock after each supply window ends. It is high exactly when that window's span equals full scale.
- R8: resMode encoding: 0 = 8-bit (full scale 255, start N 300), 1 = 10-bit (1023, 1200), 2 or 3 = 12-bit (4095, 4800).
- R9: When resMode differs from the mode in use, the next clock restarts the cycle at a ground window with N at the new mode's start. Partial counts are discarded, tracking and sampleValid are cleared, and the modulator bit on that clock is ignored.
- R10: When clipEn is high on the last clock of a pin window, the sample is limited to 0..full scale. Otherwise it is reported unclipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| resMode | input | 2 | Resolution select (see R8) |
| clipEn | input | 1 | Clip samples into the code range |
| modBit | input | 1 | Modulator output bit |
| inSel | output | 2 | Modulator input select (see R1) |
| sample | output | 32 | Signed conversion result |
| sampleValid | output | 1 | One-clock pulse per new sample |
| tracking | output | 1 | Span matched full scale on the last calibration |

## Verification
The assertions check, on every clock, that N stays within its clamp range, that N moves by at most one step and only at a cycle boundary, that ground is never followed directly by supply, that sampleValid is a single-clock pulse with sample held between pulses, that clipped results fall inside the code range, and that a mode restart clears tracking. The correctness of each count, the zero subtraction, the direction of each N step and the tracking condition can only be shown by the bench scenarios. The bench supplies known one-densities to each window, follows convergence from 300 down to 255 clocks, applies random densities that drive samples negative and over-range with and without clipping, holds a stuck supply window, and switches modes mid-window.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

  typedef enum logic [1:0] {
    PH_GND   = 2'd0,
    PH_PIN_A = 2'd1,
    PH_VIO   = 2'd2,
    PH_PIN_B = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    SPAN_EQ   = 2'd0,
    SPAN_LOW  = 2'd1,
    SPAN_HIGH = 2'd2
  } span_e;

  localparam logic [1:0] SEL_PIN = 2'd0;
  localparam logic [1:0] SEL_GND = 2'd1;
  localparam logic [1:0] SEL_VIO = 2'd2;

  typedef struct packed {
    logic   restart;
    logic   phaseEnd;
    phase_e phase;
  } ctrl_strobe_t;

endpackage

// File: rtl/adc_cal_ctrl.sv
module adc_cal_ctrl
  import adc_cal_pkg::*;
#(
  parameter int NW        = 16,
  parameter int RES_LO    = 8,
  parameter int RES_MID   = 10,
  parameter int RES_HI    = 12,
  parameter int START_LO  = 300,
  parameter int START_MID = 1200,
  parameter int START_HI  = 4800,
  parameter int MAX_MULT  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         resMode,
  input  span_e              spanCmp,
  output ctrl_strobe_t       strb,
  output logic [NW-1:0]      fullScale,
  output logic [1:0]         inSel
);

  localparam logic [NW-1:0] FS_LO   = NW'((1 << RES_LO) - 1);
  localparam logic [NW-1:0] FS_MID  = NW'((1 << RES_MID) - 1);
  localparam logic [NW-1:0] FS_HI   = NW'((1 << RES_HI) - 1);
  localparam logic [NW-1:0] ST_LO   = NW'(START_LO);
  localparam logic [NW-1:0] ST_MID  = NW'(START_MID);
  localparam logic [NW-1:0] ST_HI   = NW'(START_HI);
  localparam logic [NW-1:0] MAX_LO  = NW'(MAX_MULT * START_LO);
  localparam logic [NW-1:0] MAX_MID = NW'(MAX_MULT * START_MID);
  localparam logic [NW-1:0] MAX_HI  = NW'(MAX_MULT * START_HI);

  function automatic logic [NW-1:0] startOf(input logic [1:0] m);
    case (m)
      2'd0:    return ST_LO;
      2'd1:    return ST_MID;
      default: return ST_HI;
    endcase
  endfunction

  function automatic logic [NW-1:0] fsOf(input logic [1:0] m);
    case (m)
      2'd0:    return FS_LO;
      2'd1:    return FS_MID;
      default: return FS_HI;
    endcase
  endfunction

  function automatic logic [NW-1:0] maxOf(input logic [1:0] m);
    case (m)
      2'd0:    return MAX_LO;
      2'd1:    return MAX_MID;
      default: return MAX_HI;
    endcase
  endfunction

  logic [1:0]    modeReg;
  logic [NW-1:0] winLen;
  logic [NW-1:0] cnt;
  phase_e        phase;
  logic [NW-1:0] maxLen;
  logic [NW-1:0] nextLen;
  phase_e        nextPhase;
  logic          restart;
  logic          lastCyc;

  assign restart   = (resMode != modeReg);
  assign lastCyc   = (cnt == winLen - NW'(1));
  assign fullScale = fsOf(modeReg);
  assign maxLen    = maxOf(modeReg);

  assign strb.restart  = restart;
  assign strb.phaseEnd = lastCyc && !restart;
  assign strb.phase    = phase;

  always_comb begin
    case (phase)
      PH_GND:   nextPhase = PH_PIN_A;
      PH_PIN_A: nextPhase = PH_VIO;
      PH_VIO:   nextPhase = PH_PIN_B;
      default:  nextPhase = PH_GND;
    endcase
  end

  always_comb begin
    case (spanCmp)
      SPAN_HIGH: nextLen = (winLen > fullScale) ? winLen - NW'(1) : fullScale;
      SPAN_LOW:  nextLen = (winLen < maxLen) ? winLen + NW'(1) : maxLen;
      default:   nextLen = winLen;
    endcase
  end

  always_comb begin
    case (phase)
      PH_GND:  inSel = SEL_GND;
      PH_VIO:  inSel = SEL_VIO;
      default: inSel = SEL_PIN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeReg <= 2'd0;
      winLen  <= ST_LO;
      cnt     <= '0;
      phase   <= PH_GND;
    end else if (restart) begin
      modeReg <= resMode;
      winLen  <= startOf(resMode);
      cnt     <= '0;
      phase   <= PH_GND;
    end else if (lastCyc) begin
      cnt   <= '0;
      phase <= nextPhase;
      if (phase == PH_PIN_B) begin
        winLen <= nextLen;
      end
    end else begin
      cnt <= cnt + NW'(1);
    end
  end

  // R6
  win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (winLen >= fullScale) && (winLen <= maxLen));

  // R5
  len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> ((winLen == $past(winLen)) || (winLen == $past(winLen) + NW'(1)) ||
                  (winLen == $past(winLen) - NW'(1))));

  // R5
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !(lastCyc && phase == PH_PIN_B)) |=> $stable(winLen));

  // R1
  sel_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inSel == SEL_GND && !restart) |=> (inSel != SEL_VIO));

endmodule

// File: rtl/adc_cal_datapath.sv
module adc_cal_datapath
  import adc_cal_pkg::*;
#(
  parameter int NW    = 16,
  parameter int OUT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ctrl_strobe_t            strb,
  input  logic [NW-1:0]           fullScale,
  input  logic                    modBit,
  input  logic                    clipEn,
  output span_e                   spanCmp,
  output logic signed [OUT_W-1:0] sample,
  output logic                    sampleValid,
  output logic                    tracking
);

  logic [NW-1:0]           acc;
  logic [NW-1:0]           gndOnes;
  logic [NW-1:0]           total;
  logic signed [OUT_W-1:0] totalX;
  logic signed [OUT_W-1:0] gndX;
  logic signed [OUT_W-1:0] fsX;
  logic signed [OUT_W-1:0] delta;
  logic signed [OUT_W-1:0] clipped;

  assign total  = acc + NW'(modBit);
  assign totalX = {{(OUT_W-NW){1'b0}}, total};
  assign gndX   = {{(OUT_W-NW){1'b0}}, gndOnes};
  assign fsX    = {{(OUT_W-NW){1'b0}}, fullScale};
  assign delta  = totalX - gndX;

  always_comb begin
    clipped = delta;
    if (clipEn) begin
      if (delta < 0)        clipped = '0;
      else if (delta > fsX) clipped = fsX;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc         <= '0;
      gndOnes     <= '0;
      spanCmp     <= SPAN_EQ;
      sample      <= '0;
      sampleValid <= 1'b0;
      tracking    <= 1'b0;
    end else if (strb.restart) begin
      acc         <= '0;
      sampleValid <= 1'b0;
      tracking    <= 1'b0;
    end else begin
      sampleValid <= 1'b0;
      if (strb.phaseEnd) begin
        acc <= '0;
        case (strb.phase)
          PH_GND: gndOnes <= total;
          PH_VIO: begin
            tracking <= (delta == fsX);
            if (delta > fsX)      spanCmp <= SPAN_HIGH;
            else if (delta < fsX) spanCmp <= SPAN_LOW;
            else                  spanCmp <= SPAN_EQ;
          end
          default: begin
            sample      <= clipped;
            sampleValid <= 1'b1;
          end
        endcase
      end else begin
        acc <= total;
      end
    end
  end

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid |=> !sampleValid);

  // R4
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleValid |-> $stable(sample));

  // R10
  clip_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleValid && $past(clipEn)) |-> ((sample >= 0) && (sample <= fsX)));

  // R9
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.restart |=> (!tracking && !sampleValid));

endmodule

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer
  import adc_cal_pkg::*;
#(
  parameter int NW        = 16,
  parameter int OUT_W     = 32,
  parameter int RES_LO    = 8,
  parameter int RES_MID   = 10,
  parameter int RES_HI    = 12,
  parameter int START_LO  = 300,
  parameter int START_MID = 1200,
  parameter int START_HI  = 4800,
  parameter int MAX_MULT  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       resMode,
  input  logic             clipEn,
  input  logic             modBit,
  output logic [1:0]       inSel,
  output logic [OUT_W-1:0] sample,
  output logic             sampleValid,
  output logic             tracking
);

  ctrl_strobe_t            strb;
  span_e                   spanCmp;
  logic [NW-1:0]           fullScale;
  logic signed [OUT_W-1:0] sampleS;

  adc_cal_ctrl #(
    .NW(NW), .RES_LO(RES_LO), .RES_MID(RES_MID), .RES_HI(RES_HI),
    .START_LO(START_LO), .START_MID(START_MID), .START_HI(START_HI),
    .MAX_MULT(MAX_MULT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .resMode(resMode), .spanCmp(spanCmp),
    .strb(strb), .fullScale(fullScale), .inSel(inSel)
  );

  adc_cal_datapath #(.NW(NW), .OUT_W(OUT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .fullScale(fullScale),
    .modBit(modBit), .clipEn(clipEn), .spanCmp(spanCmp),
    .sample(sampleS), .sampleValid(sampleValid), .tracking(tracking)
  );

  assign sample = sampleS;

endmodule

// File: tb/adc_cal_sequencer_bench.sv
module adc_cal_sequencer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  resMode = 2'd0;
  logic        clipEn = 1'b0;
  logic        modBit = 1'b0;
  logic [1:0]  inSel;
  logic [31:0] sample;
  logic        sampleValid;
  logic        tracking;

  adc_cal_sequencer u_adc_cal_sequencer (
    .clk(clk), .rst_n(rst_n), .resMode(resMode), .clipEn(clipEn),
    .modBit(modBit), .inSel(inSel), .sample(sample),
    .sampleValid(sampleValid), .tracking(tracking)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int startOf(input int m);
    return (m == 0) ? 300 : (m == 1) ? 1200 : 4800;
  endfunction

  function automatic int fsOf(input int m);
    return (m == 0) ? 255 : (m == 1) ? 1023 : 4095;
  endfunction

  function automatic int selOf(input int p);
    return (p == 0) ? 1 : (p == 2) ? 2 : 0;
  endfunction

  // density generators, density in 1/1024 units
  int dG = 0, dV = 1024, dP = 512;
  int aG = 0, aV = 0, aP = 0;

  function automatic int genBit(input int sel);
    int b;
    b = 0;
    if (sel == 1) begin
      aG += dG; if (aG >= 1024) begin aG -= 1024; b = 1; end
    end else if (sel == 2) begin
      aV += dV; if (aV >= 1024) begin aV -= 1024; b = 1; end
    end else begin
      aP += dP; if (aP >= 1024) begin aP -= 1024; b = 1; end
    end
    return b;
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int mode, ph, segLen, segOnes, mGnd, mN, pendN, fsM, diff, expS;
    int cyc, stg, countdown, pendMode, b;
    bit havePend, resync, trackSeen, closedPin, firstSeg;
    string tag;
    void'($urandom(32'h5EED_0A1C));
    mode = 0; ph = 0; segLen = 0; segOnes = 0; mGnd = 0; mN = 300; pendN = 300;
    fsM = 255; cyc = 0; stg = 0; countdown = 0; pendMode = 0;
    havePend = 0; resync = 0; trackSeen = 0; firstSeg = 0;

    repeat (3) @(negedge clk);
    // R2 reset state
    chk(inSel == 2'd1, "R2 inSel", inSel, 1);
    chk(sampleValid == 1'b0, "R2 sampleValid", sampleValid, 0);
    chk(tracking == 1'b0, "R2 tracking", tracking, 0);
    chk(sample == 32'd0, "R2 sample", sample, 0);
    rst_n = 1'b1;

    while (!finished) begin
      if (resync) begin
        resync = 0;
        // R9 restart clears state
        chk(tracking == 1'b0, "R9 tracking", tracking, 0);
        chk(sampleValid == 1'b0, "R9 sampleValid", sampleValid, 0);
        chk(inSel == 2'd1, "R9 inSel", inSel, 1);
        ph = 0; segLen = 0; segOnes = 0; havePend = 0; cyc = 0;
        mN = startOf(mode); fsM = fsOf(mode); firstSeg = 1;
      end else begin
        closedPin = 0;
        if (int'(inSel) != selOf(ph)) begin
          tag = firstSeg ? "R8 length" : ((ph == 0) ? "R5 length" : "R1 length");
          firstSeg = 0;
          chk(segLen == mN, tag, segLen, mN);
          chk(segLen >= fsM && segLen <= 4 * startOf(mode), "R6 range", segLen, mN);
          chk(int'(inSel) == selOf((ph + 1) % 4), "R1 order", inSel, selOf((ph + 1) % 4));
          case (ph)
            0: begin
              mGnd = segOnes;
              if (stg == 1) begin
                clipEn = 1'($urandom % 2);
                case ($urandom % 4)
                  0: dP = 0;
                  1: dP = 1024;
                  default: dP = int'($urandom % 1025);
                endcase
              end
              if (stg == 4 && countdown == 0) begin
                pendMode = 0; countdown = 1 + int'($urandom % 300); stg = 5;
              end
            end
            2: begin
              diff = segOnes - mGnd;
              // R7 tracking reflects span match
              chk(tracking == (diff == fsM), "R7 tracking", tracking, int'(diff == fsM));
              if (diff == fsM) trackSeen = 1;
              if (diff > fsM)      pendN = (mN > fsM) ? mN - 1 : fsM;
              else if (diff < fsM) pendN = (mN < 4 * startOf(mode)) ? mN + 1 : 4 * startOf(mode);
              else                 pendN = mN;
              havePend = 1;
            end
            default: begin
              closedPin = 1;
              expS = segOnes - mGnd;
              if (clipEn) begin
                if (expS < 0) expS = 0;
                if (expS > fsM) expS = fsM;
              end
              chk(sampleValid == 1'b1, "R4 valid", sampleValid, 1);
              chk($signed(sample) == expS, clipEn ? "R10 clipped sample" : "R3 sample",
                  $signed(sample), expS);
              if (ph == 3) begin
                if (havePend) mN = pendN;
                havePend = 0;
                cyc++;
                if (stg == 1) begin
                  dG = int'($urandom % 80);
                  dV = (cyc == 5) ? 0 : 880 + int'($urandom % 145);
                end
                if (countdown == 0) begin
                  if (stg == 0 && cyc == 48) begin
                    chk(trackSeen == 1'b1, "R7 converged", trackSeen, 1);
                    chk(mN == 255, "R6 floor", mN, 255);
                    stg = 1; cyc = 0;
                  end else if (stg == 1 && cyc == 12) begin
                    stg = 2; clipEn = 0; dG = 0; dV = 1024; dP = 700;
                    pendMode = 1; countdown = 1 + int'($urandom % 400);
                  end else if (stg == 2 && cyc == 2) begin
                    stg = 3; pendMode = 2; countdown = 1 + int'($urandom % 400);
                  end else if (stg == 3 && cyc == 1) begin
                    stg = 4; pendMode = 3; countdown = 1 + int'($urandom % 400);
                  end else if (stg == 5 && cyc == 2) begin
                    finished = 1;
                  end
                end
              end
            end
          endcase
          ph = (ph + 1) % 4;
          segLen = 0; segOnes = 0;
        end
        if (!closedPin && sampleValid) chk(1'b0, "R4 stray valid", 1, 0);
      end

      if (countdown > 0) begin
        countdown--;
        if (countdown == 0) begin
          resMode = 2'(pendMode); mode = pendMode; resync = 1;
        end
      end

      b = genBit(int'(inSel));
      modBit = 1'(b);
      segOnes += b;
      segLen++;
      if (!finished) @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule